// File: doc/BRIEF.md
# Serial Command Word Decoder

This block is a serial slave that takes 16-bit command words from a host over a four-wire serial link. The serial clock, chip select and data input are brought into the system clock domain through two-stage synchronisers. While chip select is low, one bit is taken in on each rising serial clock edge, most significant bit first. When chip select rises, the block checks the length of the transfer. If the bit count is a whole multiple of 16, the last word received is split into its fields and may be written into a small bank of configuration registers.

Each word carries a watchdog bit. A word is only written if its watchdog bit is the opposite of the one in the last word that was written. Each accepted word raises a watchdog-healthy flag. The flag drops again if no accepted word arrives within a programmable number of system clocks.

A serial output presents the contents of the shift register, delayed by exactly one word, so that several devices can be chained on one chip select. A combinational read port exposes the stored registers.

Top module: `spi_cmd_decoder`

## Requirements
- R1: After an active-low reset, every stored register reads zero, the watchdog-healthy flag is low and the serial output is low.
- R2: Bits are sampled on rising serial clock edges, most significant first. In the committed 16-bit word, bit 15 is the watchdog bit, bits 14:13 the channel, bits 12:10 the register address, bit 9 reserved, and bits 8:0 the data.
- R3: A word is only considered for writing when chip select rises after a transfer of a non-zero whole multiple of 16 bits. Any other length leaves every register unchanged.
- R4: When a transfer holds several words, only the final 16 bits are decoded. Earlier words in the same transfer write nothing.
- R5: A word is written only if its watchdog bit differs from the watchdog bit of the last written word. That reference is 0 after reset.
- R6: A word whose reserved bit 9 is 1 is ignored completely: no register write and no change to the watchdog reference.
- R7: Addresses whose bit is set in PER_CH_MASK (default: addresses 2 to 7) hold one register per channel. The other addresses hold one shared register, which ignores the channel field on both write and read.
- R8: On each falling serial clock edge inside a transfer, the serial output takes the oldest bit in the 16-bit shift register. Data therefore appears on the output 16 clocks after it entered.
- R9: The watchdog-healthy flag rises one clock after an accepted word. It falls after WD_TIMEOUT system clocks with no further accepted word.
- R10: The read data shows the stored register for the given address and channel, with no clock of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out, one word behind the input |
| rd_addr | input | 3 | Read register address |
| rd_ch | input | 2 | Read channel |
| rd_data | output | 9 | Stored register value |
| wd_ok | output | 1 | Watchdog-healthy flag |

## Verification
The main decode path is driven with a mix of transfers:
- Single words with alternating watchdog bits show that the field positions are decoded correctly.
- A repeated watchdog bit and a set reserved bit show that the write gate rejects those words.
- 15- and 17-bit transfers show that the length check works.
- 32- and 48-bit transfers show that only the last word counts.

A shared register is written with a non-zero channel and read back on a different channel. This separates per-channel storage from shared storage. A daisy-chain transfer compares the serial output during the second word against the first word. A directed wait on either side of the timeout checks both edges of the watchdog flag.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int WORD_W = 16;
  localparam int DATA_W = 9;
  localparam int ADDR_W = 3;
  localparam int CH_W   = 2;

  typedef struct packed {
    logic              wd;
    logic [CH_W-1:0]   ch;
    logic [ADDR_W-1:0] addr;
    logic              rsvd;
    logic [DATA_W-1:0] data;
  } cmd_word_t;
endpackage

// File: rtl/cdc_sync.sv
module cdc_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= RST_VAL;
        else        st[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= RST_VAL;
        else        st[g] <= st[g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/frame_rx.sv
module frame_rx
  import spi_cmd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclk_s,
  input  logic      cs_n_s,
  input  logic      mosi_s,
  output logic      so,
  output logic      commit,
  output cmd_word_t word
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              sclk_d, cs_d;
  logic [WORD_W-1:0] sr;
  logic [CNT_W-1:0]  bit_cnt;
  logic              full;

  logic sclk_rise, sclk_fall, cs_rise, cs_fall;
  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign cs_rise   = cs_n_s & ~cs_d;
  assign cs_fall   = ~cs_n_s & cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      cs_d    <= 1'b1;
      sr      <= '0;
      bit_cnt <= '0;
      full    <= 1'b0;
      so      <= 1'b0;
      commit  <= 1'b0;
      word    <= '0;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_n_s;
      commit <= cs_rise && full && (bit_cnt == '0);
      if (cs_rise) word <= cmd_word_t'(sr);
      if (cs_fall) begin
        bit_cnt <= '0;
        full    <= 1'b0;
      end else if (!cs_n_s && sclk_rise) begin
        sr      <= {sr[WORD_W-2:0], mosi_s};
        bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
        if (bit_cnt == LAST) full <= 1'b1;
      end
      if (!cs_n_s && sclk_fall) so <= sr[WORD_W-1];
    end
  end

  // R3
  commit_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(cs_rise));

  // R3
  commit_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(full));
endmodule

// File: rtl/wdog_gate.sv
module wdog_gate #(
  parameter int TIMEOUT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  input  logic wd_bit,
  input  logic rsvd_bit,
  output logic accept,
  output logic wd_ok
);
  localparam int CNT_W = $clog2(TIMEOUT);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT - 1);

  logic             wd_ref;
  logic [CNT_W-1:0] cnt;

  assign accept = commit && !rsvd_bit && (wd_bit != wd_ref);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_ref <= 1'b0;
      wd_ok  <= 1'b0;
      cnt    <= '0;
    end else if (accept) begin
      wd_ref <= wd_bit;
      wd_ok  <= 1'b1;
      cnt    <= '0;
    end else if (wd_ok) begin
      if (cnt == LIMIT) begin
        wd_ok <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R9
  wd_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_ok) |-> $past(accept));

  // R9
  wd_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT);

  // R6
  rsvd_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && rsvd_bit) |=> $stable(wd_ref));
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import spi_cmd_pkg::*;
#(
  parameter logic [2**ADDR_W-1:0] PER_CH_MASK = 8'b1111_1100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [DATA_W-1:0] rd_data
);
  localparam int NUM_ADDR = 2 ** ADDR_W;
  localparam int NUM_CH   = 2 ** CH_W;
  localparam int SLOTS    = NUM_ADDR * NUM_CH;

  logic [DATA_W-1:0] store [SLOTS];
  logic [SLOTS*DATA_W-1:0] flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) store[s] <= '0;
    end else if (wr_en) begin
      for (int a = 0; a < NUM_ADDR; a++)
        for (int c = 0; c < NUM_CH; c++)
          if (wr_addr == ADDR_W'(a) &&
              (PER_CH_MASK[a] ? (wr_ch == CH_W'(c)) : (c == 0)))
            store[a*NUM_CH + c] <= wr_data;
    end
  end

  always_comb begin
    for (int s = 0; s < SLOTS; s++) flat[s*DATA_W +: DATA_W] = store[s];
  end

  logic [CH_W-1:0] rd_slot_ch;
  assign rd_slot_ch = PER_CH_MASK[rd_addr] ? rd_ch : '0;
  assign rd_data    = store[{rd_addr, rd_slot_ch}];

  // R3
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(flat));
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import spi_cmd_pkg::*;
#(
  parameter int WD_TIMEOUT = 1024,
  parameter logic [2**ADDR_W-1:0] PER_CH_MASK = 8'b1111_1100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [DATA_W-1:0] rd_data,
  output logic              wd_ok
);
  logic [2:0] pins_s;
  logic       commit, accept;
  cmd_word_t  word;

  cdc_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sclk, cs_n, mosi}), .q(pins_s)
  );

  frame_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[2]), .cs_n_s(pins_s[1]), .mosi_s(pins_s[0]),
    .so(miso), .commit(commit), .word(word)
  );

  wdog_gate #(.TIMEOUT(WD_TIMEOUT)) u_wd (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .wd_bit(word.wd), .rsvd_bit(word.rsvd),
    .accept(accept), .wd_ok(wd_ok)
  );

  cfg_bank #(.PER_CH_MASK(PER_CH_MASK)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(accept),
    .wr_addr(word.addr), .wr_ch(word.ch), .wr_data(word.data),
    .rd_addr(rd_addr), .rd_ch(rd_ch), .rd_data(rd_data)
  );

  // R5
  write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (commit && !word.rsvd));
endmodule

// File: tb/spi_cmd_decoder_test.sv
module spi_cmd_decoder_test;
  localparam int TO = 300;
  localparam logic [7:0] MASK = 8'b1111_1100;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [2:0] rd_addr = '0;
  logic [1:0] rd_ch = '0;
  logic miso, wd_ok;
  logic [8:0] rd_data;

  int n_chk = 0, n_fail = 0;
  logic [8:0] model [8][4];
  logic wref = 1'b0;

  spi_cmd_decoder #(.WD_TIMEOUT(TO), .PER_CH_MASK(MASK)) uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .rd_addr(rd_addr), .rd_ch(rd_ch), .rd_data(rd_data),
    .wd_ok(wd_ok)
  );

  always #5 clk = ~clk;

  // {bit count, filler word, final word}
  localparam logic [37:0] VEC [10] = '{
    {6'd16, 16'h0000, 16'hA8A5},
    {6'd16, 16'h0000, 16'h69FF},
    {6'd16, 16'h0000, 16'h2833},
    {6'd15, 16'h0000, 16'h8D55},
    {6'd17, 16'h0000, 16'h8D55},
    {6'd32, 16'h9C12, 16'h8D55},
    {6'd16, 16'h0000, 16'h12F0},
    {6'd16, 16'h0000, 16'h40C3},
    {6'd16, 16'h0000, 16'hA501},
    {6'd48, 16'h0000, 16'h747E}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic [1:0] c, input string tag);
    logic [1:0] ec;
    ec = MASK[a] ? c : 2'd0;
    rd_addr = a; rd_ch = c; #1;
    chk(rd_data === model[a][ec], tag, int'(rd_data), int'(model[a][ec]));
  endtask

  task automatic xfer(input int nbits, input logic [15:0] pre, input logic [15:0] w,
                      output logic [15:0] seen);
    seen = '0;
    cs_n = 1'b0; #80;
    for (int i = 0; i < nbits; i++) begin
      logic b;
      if (nbits >= 16)
        b = (i < nbits - 16) ? pre[15 - (i % 16)] : w[15 - (i - (nbits - 16))];
      else
        b = w[15 - i];
      sclk = 1'b0; mosi = b; #70;
      if (i >= 16 && i < 32) seen[31 - i] = miso;
      #10; sclk = 1'b1; #80;
    end
    sclk = 1'b0; #80;
    cs_n = 1'b1; #120;
  endtask

  // bench model of the write rule
  task automatic model_commit(input int nbits, input logic [15:0] w, output string tag);
    bit valid;
    valid = (nbits % 16 == 0) && nbits >= 16;
    if (!valid) tag = "R3";
    else if (w[9]) tag = "R6";
    else if (w[15] == wref) tag = "R5";
    else begin
      tag = (nbits > 16) ? "R4" : "R2";
      wref = w[15];
      model[w[12:10]][MASK[w[12:10]] ? w[14:13] : 2'd0] = w[8:0];
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] seen;
    string tag;
    for (int a = 0; a < 8; a++) for (int c = 0; c < 4; c++) model[a][c] = '0;
    #32; rst_n = 1'b1; #20;
    // R1 reset state
    chk(wd_ok === 1'b0, "R1 wd_ok", int'(wd_ok), 0);
    chk(miso === 1'b0, "R1 miso", int'(miso), 0);
    rd(3'd0, 2'd0, "R1 reg0"); rd(3'd5, 2'd3, "R1 reg5");

    for (int k = 0; k < 10; k++) begin
      int nb;
      nb = int'(VEC[k][37:32]);
      xfer(nb, VEC[k][31:16], VEC[k][15:0], seen);
      model_commit(nb, VEC[k][15:0], tag);
      rd(VEC[k][12:10], VEC[k][14:13], tag);
    end

    // R7 shared and per-channel storage
    rd(3'd0, 2'd1, "R7 shared"); rd(3'd0, 2'd3, "R7 shared");
    rd(3'd2, 2'd1, "R7 per-ch"); rd(3'd2, 2'd3, "R7 per-ch"); rd(3'd2, 2'd0, "R7 per-ch");
    // R4 filler word not written
    rd(3'd7, 2'd0, "R4 filler");
    // R10 read with no delay
    rd_addr = 3'd5; rd_ch = 2'd3; #1;
    chk(rd_data === 9'h07E, "R10 read", int'(rd_data), 'h07E);

    // R8 daisy chain: second word time carries first word
    xfer(32, 16'h3C5A, 16'h0000, seen);
    chk(seen === 16'h3C5A, "R8 chain", int'(seen), 'h3C5A);
    rd(3'd7, 2'd1, "R5 no toggle");

    // R9 watchdog flag
    chk(wd_ok === 1'b0, "R9 expired", int'(wd_ok), 0);
    xfer(16, 16'h0000, 16'hD805, seen);
    model_commit(16, 16'hD805, tag);
    rd(3'd6, 2'd2, tag);
    #1000;
    chk(wd_ok === 1'b1, "R9 healthy", int'(wd_ok), 1);
    #3000;
    chk(wd_ok === 1'b0, "R9 timeout", int'(wd_ok), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule